// File: doc/BRIEF.md
# Right-Wall-Following Maze Robot Controller

This block steers a two-antenna robot out of a maze. The robot keeps its right antenna against a wall and follows it. Each clock cycle the block reads two contact sensors, one per antenna, and issues movement commands: a forward step, a small left turn and a small right turn. The commands depend only on the current state, so this is a Moore machine.

The state machine has four states held in a 2-bit register. The robot starts by searching forward for any wall. When it touches one it pivots left until it is free. It then alternates between veering right toward the wall and veering left away from it. A corner is handled by the same state that veers right. The sensors are assumed to be synchronous to the clock already. The state register samples them on every rising edge.

Top module: `mazebot_top`

## Requirements
- R1: The state code on `stateCode` is 2'b00 for Seek, 2'b01 for Pivot, 2'b10 for Hug and 2'b11 for Veer. When `rst` is high at a rising edge, the next state is Seek, whatever the sensor values.
- R2: In Seek, the machine moves to Pivot on the next edge if `sensL` or `sensR` is 1. It stays in Seek if both are 0.
- R3: In Pivot, the machine stays in Pivot while either sensor is 1. It moves to Hug when both sensors are 0.
- R4: In Hug, the machine moves to Veer when `sensR` is 1 and stays in Hug when `sensR` is 0. `sensL` has no effect in this state.
- R5: In Veer, the machine moves to Pivot when `sensL` is 1, to Hug when both sensors are 0, and stays in Veer when only `sensR` is 1.
- R6: In Seek, the outputs are `stepFwd`=1, `turnLeft`=0 and `turnRight`=0.
- R7: In Pivot, the outputs are `turnLeft`=1, `stepFwd`=0 and `turnRight`=0.
- R8: In Hug, the outputs are `turnRight`=1, `stepFwd`=1 and `turnLeft`=0.
- R9: In Veer, the outputs are `turnLeft`=1, `stepFwd`=1 and `turnRight`=0.
- R10: The outputs depend only on the registered state. A change on a sensor between clock edges leaves them unchanged. `turnLeft` and `turnRight` are never both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the state updates on its rising edge |
| rst | input | 1 | Synchronous active-high reset to Seek |
| sensL | input | 1 | Left antenna contact, 1 while it touches something |
| sensR | input | 1 | Right antenna contact, 1 while it touches something |
| stepFwd | output | 1 | Command to take one forward step |
| turnLeft | output | 1 | Command to turn a small angle to the left |
| turnRight | output | 1 | Command to turn a small angle to the right |
| stateCode | output | 2 | Current state code (see R1) |

## Verification
A wrong transition appears on `stateCode` one edge after the sensor pair that caused it. It also shows in the command outputs in the same cycle, because every state drives a distinct command pattern. The bench drives each of the four states into each of the four sensor combinations and compares the result against a model written from the transition rules. It then runs a long pseudo-random sensor sequence, which catches errors that only show after a chain of transitions, including a reset in the middle of the run. The bench also moves the sensors between edges to confirm that the commands depend only on the registered state.

// File: rtl/mazebot_pkg.sv
package mazebot_pkg;
  localparam int STATE_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_SEEK  = 2'b00,
    ST_PIVOT = 2'b01,
    ST_HUG   = 2'b10,
    ST_VEER  = 2'b11
  } botState_e;

  // one strobe per possible target; all low means hold
  typedef struct packed {
    logic toPivot;
    logic toHug;
    logic toVeer;
  } moveStrobes_t;
endpackage

// File: rtl/mazebot_ctrl.sv
module mazebot_ctrl
  import mazebot_pkg::*;
(
  input  botState_e    curState,
  input  logic         sensL,
  input  logic         sensR,
  output moveStrobes_t mv
);
  logic anyTouch;
  assign anyTouch = sensL | sensR;

  always_comb begin
    mv = '0;
    unique case (curState)
      ST_SEEK:  mv.toPivot = anyTouch;
      ST_PIVOT: mv.toHug   = ~anyTouch;
      ST_HUG:   mv.toVeer  = sensR;
      ST_VEER: begin
        mv.toPivot = sensL;
        mv.toHug   = ~anyTouch;
      end
      default:  mv = '0;
    endcase
  end

  always_comb begin
    assert_strobe_single_R5: assert ($onehot0(mv));
  end
endmodule

// File: rtl/mazebot_dpath.sv
module mazebot_dpath
  import mazebot_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  moveStrobes_t mv,
  output botState_e    stateQ,
  output logic         stepFwd,
  output logic         turnLeft,
  output logic         turnRight
);
  always_ff @(posedge clk) begin
    if (rst)             stateQ <= ST_SEEK;
    else if (mv.toPivot) stateQ <= ST_PIVOT;
    else if (mv.toHug)   stateQ <= ST_HUG;
    else if (mv.toVeer)  stateQ <= ST_VEER;
  end

  always_comb begin
    stepFwd   = 1'b0;
    turnLeft  = 1'b0;
    turnRight = 1'b0;
    unique case (stateQ)
      ST_SEEK:  stepFwd = 1'b1;
      ST_PIVOT: turnLeft = 1'b1;
      ST_HUG:   begin stepFwd = 1'b1; turnRight = 1'b1; end
      ST_VEER:  begin stepFwd = 1'b1; turnLeft  = 1'b1; end
      default:  stepFwd = 1'b0;
    endcase
  end

  assert_reset_seek_R1: assert property (@(posedge clk) rst |=> stateQ == ST_SEEK);
  assert_hold_when_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (mv == '0) |=> $stable(stateQ));
  assert_pivot_taken_R2: assert property (@(posedge clk) disable iff (rst)
    mv.toPivot |=> stateQ == ST_PIVOT);
  assert_turns_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(turnLeft && turnRight));
endmodule

// File: rtl/mazebot_top.sv
module mazebot_top
  import mazebot_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  logic                sensL,
  input  logic                sensR,
  output logic                stepFwd,
  output logic                turnLeft,
  output logic                turnRight,
  output logic [STATE_W-1:0]  stateCode
);
  botState_e    stateQ;
  moveStrobes_t mv;

  mazebot_ctrl u_ctrl (
    .curState (stateQ),
    .sensL    (sensL),
    .sensR    (sensR),
    .mv       (mv)
  );

  mazebot_dpath u_dpath (
    .clk       (clk),
    .rst       (rst),
    .mv        (mv),
    .stateQ    (stateQ),
    .stepFwd   (stepFwd),
    .turnLeft  (turnLeft),
    .turnRight (turnRight)
  );

  assign stateCode = stateQ;

  assert_seek_touch_R2: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b00 && (sensL || sensR)) |=> stateCode == 2'b01);
  assert_pivot_free_R3: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b01 && !sensL && !sensR) |=> stateCode == 2'b10);
  assert_hug_ignores_left_R4: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b10) |=> stateCode == ($past(sensR) ? 2'b11 : 2'b10));
  assert_veer_left_hit_R5: assert property (@(posedge clk) disable iff (rst)
    (stateCode == 2'b11 && sensL) |=> stateCode == 2'b01);
  assert_right_turn_moves_R8: assert property (@(posedge clk) disable iff (rst)
    turnRight |-> stepFwd);
endmodule

// File: tb/tb_mazebot_top.sv
module tb_mazebot_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sensL = 1'b0;
  logic sensR = 1'b0;
  logic stepFwd, turnLeft, turnRight;
  logic [1:0] stateCode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mazebot_top dut (
    .clk(clk), .rst(rst), .sensL(sensL), .sensR(sensR),
    .stepFwd(stepFwd), .turnLeft(turnLeft), .turnRight(turnRight),
    .stateCode(stateCode)
  );

  function automatic logic [1:0] modelNext(logic [1:0] s, logic l, logic r);
    case (s)
      2'b00: return (l | r) ? 2'b01 : 2'b00;
      2'b01: return (l | r) ? 2'b01 : 2'b10;
      2'b10: return r ? 2'b11 : 2'b10;
      default: return l ? 2'b01 : (r ? 2'b11 : 2'b10);
    endcase
  endfunction

  // {stepFwd, turnLeft, turnRight}
  function automatic logic [2:0] modelCmd(logic [1:0] s);
    case (s)
      2'b00: return 3'b100;
      2'b01: return 3'b010;
      2'b10: return 3'b101;
      default: return 3'b110;
    endcase
  endfunction

  function automatic string cmdReq(logic [1:0] s);
    case (s)
      2'b00: return "R6";
      2'b01: return "R7";
      2'b10: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic string nextReq(logic [1:0] s);
    case (s)
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic check(string req, logic [2:0] act, logic [2:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic checkState(string req, logic [1:0] exp);
    check(req, {1'b0, stateCode}, {1'b0, exp});
    check(cmdReq(exp), {stepFwd, turnLeft, turnRight}, modelCmd(exp));
    if (turnLeft && turnRight) check("R10", 3'b011, 3'b000);
  endtask

  task automatic goTo(logic [1:0] s);
    rst = 1'b1; sensL = 1'b0; sensR = 1'b0;
    tick();
    rst = 1'b0;
    if (s != 2'b00) begin sensL = 1'b1; tick(); end
    if (s[1])       begin sensL = 1'b0; sensR = 1'b0; tick(); end
    if (s == 2'b11) begin sensR = 1'b1; tick(); end
  endtask

  initial begin
    #400000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [1:0] exp;
    logic [7:0] lfsr;
    // R1 reset state, with sensors active during reset
    rst = 1'b1; sensL = 1'b1; sensR = 1'b1;
    tick(); tick();
    checkState("R1", 2'b00);
    rst = 1'b0;

    // exhaustive sweep: every state x every sensor pair
    for (int s = 0; s < 4; s++) begin
      for (int p = 0; p < 4; p++) begin
        goTo(s[1:0]);
        checkState("R1", s[1:0]);
        sensL = p[1]; sensR = p[0];
        tick();
        checkState(nextReq(s[1:0]), modelNext(s[1:0], p[1], p[0]));
      end
    end

    // R10: sensor motion between edges leaves commands unchanged
    for (int s = 0; s < 4; s++) begin
      goTo(s[1:0]);
      for (int p = 0; p < 4; p++) begin
        sensL = p[1]; sensR = p[0];
        #0.2;
        check("R10", {stepFwd, turnLeft, turnRight}, modelCmd(s[1:0]));
      end
      sensL = 1'b0; sensR = 1'b0;
    end

    // long pseudo-random run with a reset in the middle
    goTo(2'b00);
    exp = 2'b00;
    lfsr = 8'hA5;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      sensL = lfsr[0]; sensR = lfsr[3];
      rst = (i == 200);
      exp = rst ? 2'b00 : modelNext(exp, sensL, sensR);
      tick();
      checkState(rst ? "R1" : "R5", exp);
    end
    rst = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule